// File: doc/BRIEF.md
# Time base and decrementer timer

This block is the timer unit of a processor. It holds a free-running 64-bit time base and a 32-bit decrementer that counts down. Both advance only in cycles where the tick enable is high. A prescaler outside the block produces that enable. Software reaches the counters through a small register port. A 2-bit selector picks the lower time-base half, the upper time-base half or the decrementer. Writes of 32 bits go to the half or counter that is selected. Reads are combinational through a second selector.

The decrementer requests the timer interrupt in two cases. The first is when it runs past zero. It then reloads with all ones and keeps counting. The second is when software writes a value with the top bit set while the current value has its top bit clear. The request is a level that stays high until the core pulses an acknowledge.

Top module: `tbdec_timer`

## Requirements
- R1: During and after a synchronous active-low reset, the time base reads zero in both halves, the decrementer reads 0xFFFFFFFF and the interrupt request is low.
- R2: In a cycle with tick_en high and no time-base write, the 64-bit time base increases by exactly one, carrying from bit 31 into bit 32. With tick_en low it holds.
- R3: rd_data shows, combinationally, time-base bits 31:0 for rd_sel 0, bits 63:32 for rd_sel 1, the decrementer for rd_sel 2, and zero for rd_sel 3.
- R4: A write with reg_sel 0 replaces time-base bits 31:0 and keeps bits 63:32. A write with reg_sel 1 replaces bits 63:32 and keeps bits 31:0. In either case the tick of that cycle is not applied to the time base.
- R5: The decrementer decreases by one in each cycle where tick_en is high and no decrementer write is made. A write with reg_sel 2 loads reg_wdata and takes priority over a tick in the same cycle.
- R6: A tick while the decrementer holds zero raises the interrupt request and leaves the decrementer at 0xFFFFFFFF. A written zero therefore expires on the first tick after the write, never in the write cycle itself.
- R7: A decrementer write whose bit 31 is 1, made while the current decrementer bit 31 is 0, raises the interrupt request in the next cycle. A write of any other combination raises nothing.
- R8: The interrupt request stays high until an irq_ack cycle clears it for the next cycle. If a new raise falls in the same cycle as the acknowledge, the request stays high.
- R9: A write with reg_sel 3 changes neither the time base, the decrementer nor the interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Time-base tick enable from the prescaler |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write target: 0 TB low, 1 TB high, 2 decrementer, 3 none |
| reg_wdata | input | 32 | Write data |
| rd_sel | input | 2 | Read selector, same encoding as reg_sel |
| rd_data | output | 32 | Combinational read data |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Level timer-interrupt request |

## Verification
The counters are first driven by plain runs of ticks with gaps. The lower half is then loaded just below its limit, so that the carry into the upper half is the only thing that differs from a 32-bit counter. Writes are made in cycles where the tick is high, to show that the write wins. Zero and small decrementer values are loaded and ticked through expiry. The sign-bit rule is tried with each of the four combinations of old and new top bit, so that the raise from a write can be told apart from the raise on expiry. A long stretch of mixed random ticks, writes and acknowledges, with an acknowledge landing on a raise, is compared every cycle against a behavioural model.

// File: rtl/tbd_pkg.sv
// Shared types of the time base / decrementer timer.
package tbd_pkg;
    // Register selector; the encoding is visible at the ports.
    typedef enum logic [1:0] {
        SEL_TB_LO = 2'd0,
        SEL_TB_HI = 2'd1,
        SEL_DEC   = 2'd2,
        SEL_NONE  = 2'd3
    } tbd_sel_e;
endpackage

// File: rtl/tbd_timebase.sv
// Free-running time base of two DATA_W halves.
// Assumes at most one half is written per cycle; a write suppresses that cycle's tick.
module tbd_timebase #(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_en,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic [DATA_W-1:0]     wdata,
    output logic [2*DATA_W-1:0]   tb_q
);
    localparam int TB_W   = 2 * DATA_W;
    localparam int HALVES = 2;

    logic [TB_W-1:0]   tb_inc;
    logic [TB_W-1:0]   tb_nxt;
    logic [HALVES-1:0] wr_half;
    logic              any_wr;

    assign tb_inc  = tb_q + TB_W'(1);
    assign wr_half = {wr_hi, wr_lo};
    assign any_wr  = |wr_half;

    // Per half: take write data, else the held value on a foreign write, else the tick.
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        always_comb begin
            if (wr_half[h])
                tb_nxt[h*DATA_W +: DATA_W] = wdata;
            else if (any_wr || !tick_en)
                tb_nxt[h*DATA_W +: DATA_W] = tb_q[h*DATA_W +: DATA_W];
            else
                tb_nxt[h*DATA_W +: DATA_W] = tb_inc[h*DATA_W +: DATA_W];
        end
    end

    // Time-base register.
    always_ff @(posedge clk) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_nxt;
    end

    AST_TB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !any_wr) |=> (tb_q == $past(tb_q) + TB_W'(1))); // R2
    AST_TB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !any_wr) |=> $stable(tb_q)); // R2
    AST_TB_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (tb_q[TB_W-1:DATA_W] == $past(tb_q[TB_W-1:DATA_W]))); // R4
    AST_TB_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (tb_q[DATA_W-1:0] == $past(tb_q[DATA_W-1:0]))); // R4
endmodule

// File: rtl/tbd_decrementer.sv
// Down-counting decrementer. Expiry is the tick that takes it from zero to all ones.
// Flags a write that turns the sign bit on. Assumes the write has priority over the tick.
module tbd_decrementer #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] dec_q,
    output logic              expire,
    output logic              sign_raise
);
    localparam int MSB = DATA_W - 1;

    logic do_tick;

    assign do_tick    = tick_en && !wr;
    // Expiry: a tick applied while the count is zero.
    assign expire     = do_tick && (dec_q == '0);
    // Raise on write: new sign bit set while the old one is clear.
    assign sign_raise = wr && wdata[MSB] && !dec_q[MSB];

    // Counter register; a write wins and zero wraps to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)       dec_q <= '1;
        else if (wr)      dec_q <= wdata;
        else if (do_tick) dec_q <= dec_q - DATA_W'(1);
    end

    AST_DEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (dec_q == $past(wdata))); // R5
    AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr) |=> $stable(dec_q)); // R5
    AST_DEC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr && dec_q == '0) |=> (dec_q == '1)); // R6
endmodule

// File: rtl/tbd_irq.sv
// Level timer-interrupt flag: set by either raise source, cleared by an acknowledge.
// Assumes a raise in the acknowledge cycle wins.
module tbd_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic raise_exp,
    input  logic raise_wr,
    input  logic ack,
    output logic irq_q
);
    logic raise;

    assign raise = raise_exp || raise_wr;

    // Interrupt flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)     irq_q <= 1'b0;
        else if (raise) irq_q <= 1'b1;
        else if (ack)   irq_q <= 1'b0;
    end

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        raise_exp |=> irq_q); // R6
    AST_IRQ_WRITE_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        raise_wr |=> irq_q); // R7
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !ack) |=> irq_q); // R8
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !raise) |=> !irq_q); // R8
endmodule

// File: rtl/tbdec_timer.sv
// Timer unit top: time base, decrementer, interrupt flag and read mux.
// Assumes tick_en is a one-cycle enable from an external prescaler.
module tbdec_timer #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              irq_ack,
    output logic              irq
);
    import tbd_pkg::*;

    localparam int TB_W = 2 * DATA_W;

    logic [TB_W-1:0]   tb_q;
    logic [DATA_W-1:0] dec_q;
    logic              wr_lo, wr_hi, wr_dec;
    logic              expire, sign_raise;
    tbd_sel_e          wsel, rsel;

    assign wsel   = tbd_sel_e'(reg_sel);
    assign rsel   = tbd_sel_e'(rd_sel);
    assign wr_lo  = reg_wr && (wsel == SEL_TB_LO);
    assign wr_hi  = reg_wr && (wsel == SEL_TB_HI);
    assign wr_dec = reg_wr && (wsel == SEL_DEC);

    tbd_timebase #(.DATA_W(DATA_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(reg_wdata), .tb_q(tb_q)
    );

    tbd_decrementer #(.DATA_W(DATA_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr(wr_dec),
        .wdata(reg_wdata), .dec_q(dec_q), .expire(expire), .sign_raise(sign_raise)
    );

    tbd_irq u_irq (
        .clk(clk), .rst_n(rst_n), .raise_exp(expire), .raise_wr(sign_raise),
        .ack(irq_ack), .irq_q(irq)
    );

    // Combinational read mux over the current counter values.
    always_comb begin
        case (rsel)
            SEL_TB_LO: rd_data = tb_q[DATA_W-1:0];
            SEL_TB_HI: rd_data = tb_q[TB_W-1:DATA_W];
            SEL_DEC:   rd_data = dec_q;
            default:   rd_data = '0;
        endcase
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (tb_q == '0 && dec_q == '1 && !irq)); // R1
    AST_NONE_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && wsel == SEL_NONE && !tick_en && !irq_ack)
            |=> ($stable(tb_q) && $stable(dec_q) && $stable(irq))); // R9
endmodule

// File: tb/tbdec_timer_tb.sv
module tbdec_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic        irq_ack = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    // Behavioural reference state.
    longint unsigned m_tb  = 0;
    logic [31:0]     m_dec = 32'hFFFF_FFFF;
    bit              m_irq = 1'b0;

    always #5 clk = ~clk;

    tbdec_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .rd_sel(rd_sel),
        .rd_data(rd_data), .irq_ack(irq_ack), .irq(irq)
    );

    task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Sweep all read selectors (R3) and the irq pin at the negative edge.
    task automatic check_all(string tag);
        for (int s = 0; s < 4; s++) begin
            logic [31:0] exp;
            rd_sel = 2'(s);
            #1;
            case (s)
                0: exp = m_tb[31:0];
                1: exp = m_tb[63:32];
                2: exp = m_dec;
                default: exp = 32'h0;
            endcase
            if (s == 3) cmp("R3", "rd_sel=3", rd_data, exp);
            else        cmp(tag, $sformatf("rd_sel=%0d", s), rd_data, exp);
        end
        cmp(tag, "irq", {31'b0, irq}, {31'b0, m_irq});
    endtask

    // One clock: drive, update the model at the edge, compare at the next negedge.
    task automatic step(string tag, bit tk, bit wr, logic [1:0] sel,
                        logic [31:0] wd, bit ack);
        bit set;
        tick_en = tk; reg_wr = wr; reg_sel = sel; reg_wdata = wd; irq_ack = ack;
        @(posedge clk);
        set = 1'b0;
        if (wr && sel == 2'd2) begin
            if (wd[31] && !m_dec[31]) set = 1'b1;
            m_dec = wd;
        end else if (tk) begin
            if (m_dec == 32'h0) set = 1'b1;
            m_dec = m_dec - 32'd1;
        end
        if (wr && sel == 2'd0)      m_tb = {m_tb[63:32], wd};
        else if (wr && sel == 2'd1) m_tb = {wd, m_tb[31:0]};
        else if (tk)                m_tb = m_tb + 64'd1;
        m_irq = set | (m_irq & ~ack);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state, including ticks and writes held off by reset.
        tick_en = 1'b1; reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; tick_en = 1'b0; reg_wr = 1'b0;
        check_all("R1");

        // R2, R5: ticks with gaps.
        for (int i = 0; i < 12; i++) step("R2", (i % 3) != 1, 1'b0, 2'd0, 0, 1'b0);

        // R2: carry from the low half into the high half.
        step("R4", 1'b0, 1'b1, 2'd0, 32'hFFFF_FFFD, 1'b0);
        for (int i = 0; i < 5; i++) step("R2", 1'b1, 1'b0, 2'd0, 0, 1'b0);

        // R4: half writes with the tick high; tick must not apply.
        step("R4", 1'b1, 1'b1, 2'd1, 32'hA5A5_0001, 1'b0);
        step("R4", 1'b1, 1'b1, 2'd0, 32'h1234_5678, 1'b0);
        step("R2", 1'b1, 1'b0, 2'd0, 0, 1'b0);

        // R9: writes to selector 3 with and without tick.
        step("R9", 1'b0, 1'b1, 2'd3, 32'hDEAD_BEEF, 1'b0);
        step("R9", 1'b1, 1'b1, 2'd3, 32'h8000_0000, 1'b0);

        // R5, R6: load 3 with tick high, count through expiry.
        step("R5", 1'b1, 1'b1, 2'd2, 32'h3, 1'b0);
        for (int i = 0; i < 5; i++) step("R6", 1'b1, 1'b0, 2'd0, 0, 1'b0);

        // R8: held without ack, then cleared.
        step("R8", 1'b0, 1'b0, 2'd0, 0, 1'b0);
        step("R8", 1'b0, 1'b0, 2'd0, 0, 1'b1);
        step("R8", 1'b0, 1'b0, 2'd0, 0, 1'b0);

        // R6: written zero expires on the next tick, not the write cycle.
        step("R6", 1'b1, 1'b1, 2'd2, 32'h0, 1'b0);
        step("R6", 1'b0, 1'b0, 2'd0, 0, 1'b0);
        step("R6", 1'b1, 1'b0, 2'd0, 0, 1'b0);
        step("R8", 1'b0, 1'b0, 2'd0, 0, 1'b1);

        // R7: all four sign combinations (decrementer currently negative).
        step("R7", 1'b0, 1'b1, 2'd2, 32'h8000_0000, 1'b0);
        step("R7", 1'b0, 1'b1, 2'd2, 32'h0000_0010, 1'b0);
        step("R7", 1'b0, 1'b1, 2'd2, 32'h0000_0020, 1'b0);
        step("R7", 1'b0, 1'b1, 2'd2, 32'hC000_0000, 1'b0);
        step("R8", 1'b0, 1'b0, 2'd0, 0, 1'b1);
        step("R7", 1'b0, 1'b1, 2'd2, 32'h8000_0001, 1'b0);

        // R8: raise in the acknowledge cycle keeps the request set.
        step("R8", 1'b0, 1'b1, 2'd2, 32'h1, 1'b0);
        step("R8", 1'b1, 1'b0, 2'd0, 0, 1'b0);
        step("R8", 1'b1, 1'b0, 2'd0, 0, 1'b1);
        step("R8", 1'b0, 1'b0, 2'd0, 0, 1'b0);
        step("R8", 1'b0, 1'b1, 2'd2, 32'h7FFF_FFFF, 1'b1);
        step("R7", 1'b0, 1'b1, 2'd2, 32'hFFFF_FFF0, 1'b1);

        // Mixed random stretch against the model.
        for (int i = 0; i < 400; i++) begin
            int unsigned r;
            logic [31:0] wd;
            r  = $urandom;
            wd = (r[7:6] == 2'd0) ? 32'($urandom % 4) : $urandom;
            step("R5", r[0] | r[1], r[4:2] == 3'd0, r[9:8], wd, r[12:10] == 3'd0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule